// File: doc/BRIEF.md
# Card Socket Address Window Decoder

This block decides whether a host bus cycle belongs to an attached card slot. It holds two I/O windows and five system memory windows. Each window has an inclusive start bound, an inclusive stop bound and an enable bit. Software programs all of these through a byte-wide indexed register port. On every cycle the block compares the host address with every enabled window of the matching cycle kind. When a window matches, the block claims the cycle and reports the lowest-numbered matching window of each kind.

I/O windows compare the low 16 address bits, so they resolve down to a single byte. Memory windows compare address bits 23..12, so they resolve to 4 KB pages within a 24-bit space. Each memory window also carries two attributes: a 16-bit data path select and a request for a zero-wait-state response. The card's active-low wait input vetoes the zero-wait-state response. Decoding is purely combinational from the address and cycle-kind inputs to the outputs. Register writes take effect at the next clock edge.

No payload streams through the block, so it has no valid/ready interface and never applies back-pressure. Every pin is a plain level-sensitive control or status signal, sampled or updated on the rising clock edge.

Top module: `sock_win_dec`

## Requirements
- R1: After reset every register reads back 0x00 and no window produces a hit; `claim` is 0 and `nows_n` is 1.
- R2: Register layout. I/O window w starts at index 08h+4w and holds four bytes: start[7:0], start[15:8], stop[7:0], stop[15:8]. Memory window m starts at index 10h+8m and holds four bytes: start A[19:12]; {bit7 = 16-bit path, bit6 = zero-wait request, bits3:0 = start A[23:20]}; stop A[19:12]; {bits3:0 = stop A[23:20]}. The enable byte at index 06h holds memory window m at bit m and I/O window w at bit 6+w. Any unused bit reads 0. Any other index reads 0x00, and a write to it has no effect.
- R3: An I/O window hits when `io_cyc` is 1, the window is enabled and start <= `bus_addr[15:0]` <= stop. Address bits 23..16 are ignored for this compare.
- R4: A memory window hits when `mem_cyc` is 1, the window is enabled and start <= `bus_addr[23:12]` <= stop.
- R5: A disabled window never hits, whatever its bounds.
- R6: When several windows of one kind hit, `io_win` or `mem_win` reports the lowest-numbered one, and its attributes are the ones used.
- R7: `bus16` equals the 16-bit path bit of the reported memory window when `mem_hit` is 1, and is 0 otherwise.
- R8: `nows_n` is 0 exactly when `mem_hit` is 1, the reported window's zero-wait request bit is 1 and `card_wait_n` is 1.
- R9: `claim` equals `io_hit | mem_hit`. I/O windows ignore memory cycles and memory windows ignore I/O cycles.
- R10: Decode outputs follow the address inputs in the same cycle. A register write changes the decode only after the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the indexed register port |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read-back byte at `reg_idx` |
| bus_addr | input | 24 | Host cycle address |
| io_cyc | input | 1 | Current host cycle is an I/O cycle |
| mem_cyc | input | 1 | Current host cycle is a memory cycle |
| card_wait_n | input | 1 | Card wait request, active low |
| claim | output | 1 | Cycle is claimed for the card slot |
| io_hit | output | 1 | Some I/O window matched |
| io_win | output | 1 | Number of the reported I/O window |
| mem_hit | output | 1 | Some memory window matched |
| mem_win | output | 3 | Number of the reported memory window |
| bus16 | output | 1 | 16-bit data path for this cycle |
| nows_n | output | 1 | Zero-wait-state response to the host, active low |

## Verification
A register write and a decode can fall in the same cycle. The bench provokes this by holding a host address on a window edge while it rewrites that window's stop byte. At the negedge before the write's clock edge it expects the decision made under the old bound, and one cycle later the decision made under the new one. The zero-wait request and the card's wait input also meet in one cycle: the bench drops `card_wait_n` while a zero-wait window is hit. It then expects `nows_n` to rise while `mem_hit` and `mem_win` stay as they were.

// File: rtl/sock_win_pkg.sv
package sock_win_pkg;
  localparam int IDX_EN     = 8'h06;
  localparam int IO_BASE    = 8'h08;
  localparam int IO_STRIDE  = 4;
  localparam int MEM_BASE   = 8'h10;
  localparam int MEM_STRIDE = 8;
  localparam int IO_AW      = 16;
  localparam int PAGE_W     = 12;
  localparam int IO_EN_BIT  = 6;

  function automatic logic [7:0] idx8(input int v);
    return v[7:0];
  endfunction
endpackage

// File: rtl/sock_win_regs.sv
module sock_win_regs
  import sock_win_pkg::*;
#(
  parameter int N_IO  = 2,
  parameter int N_MEM = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [7:0]                    reg_idx,
  input  logic [7:0]                    reg_wdata,
  output logic [7:0]                    reg_rdata,
  output logic [N_IO-1:0][IO_AW-1:0]    io_lo,
  output logic [N_IO-1:0][IO_AW-1:0]    io_hi,
  output logic [N_IO-1:0]               io_en,
  output logic [N_MEM-1:0][PAGE_W-1:0]  mem_lo,
  output logic [N_MEM-1:0][PAGE_W-1:0]  mem_hi,
  output logic [N_MEM-1:0]              mem_en,
  output logic [N_MEM-1:0]              mem_w16,
  output logic [N_MEM-1:0]              mem_zws
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_lo   <= '0;
      io_hi   <= '0;
      io_en   <= '0;
      mem_lo  <= '0;
      mem_hi  <= '0;
      mem_en  <= '0;
      mem_w16 <= '0;
      mem_zws <= '0;
    end else if (reg_wr) begin
      if (reg_idx == idx8(IDX_EN)) begin
        mem_en <= reg_wdata[N_MEM-1:0];
        io_en  <= reg_wdata[IO_EN_BIT +: N_IO];
      end
      for (int w = 0; w < N_IO; w++) begin
        if (reg_idx == idx8(IO_BASE + IO_STRIDE*w + 0)) io_lo[w][7:0]  <= reg_wdata;
        if (reg_idx == idx8(IO_BASE + IO_STRIDE*w + 1)) io_lo[w][15:8] <= reg_wdata;
        if (reg_idx == idx8(IO_BASE + IO_STRIDE*w + 2)) io_hi[w][7:0]  <= reg_wdata;
        if (reg_idx == idx8(IO_BASE + IO_STRIDE*w + 3)) io_hi[w][15:8] <= reg_wdata;
      end
      for (int m = 0; m < N_MEM; m++) begin
        if (reg_idx == idx8(MEM_BASE + MEM_STRIDE*m + 0)) mem_lo[m][7:0] <= reg_wdata;
        if (reg_idx == idx8(MEM_BASE + MEM_STRIDE*m + 1)) begin
          mem_w16[m]      <= reg_wdata[7];
          mem_zws[m]      <= reg_wdata[6];
          mem_lo[m][11:8] <= reg_wdata[3:0];
        end
        if (reg_idx == idx8(MEM_BASE + MEM_STRIDE*m + 2)) mem_hi[m][7:0]  <= reg_wdata;
        if (reg_idx == idx8(MEM_BASE + MEM_STRIDE*m + 3)) mem_hi[m][11:8] <= reg_wdata[3:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_idx == idx8(IDX_EN)) begin
      reg_rdata[N_MEM-1:0]          = mem_en;
      reg_rdata[IO_EN_BIT +: N_IO]  = io_en;
    end
    for (int w = 0; w < N_IO; w++) begin
      if (reg_idx == idx8(IO_BASE + IO_STRIDE*w + 0)) reg_rdata = io_lo[w][7:0];
      if (reg_idx == idx8(IO_BASE + IO_STRIDE*w + 1)) reg_rdata = io_lo[w][15:8];
      if (reg_idx == idx8(IO_BASE + IO_STRIDE*w + 2)) reg_rdata = io_hi[w][7:0];
      if (reg_idx == idx8(IO_BASE + IO_STRIDE*w + 3)) reg_rdata = io_hi[w][15:8];
    end
    for (int m = 0; m < N_MEM; m++) begin
      if (reg_idx == idx8(MEM_BASE + MEM_STRIDE*m + 0)) reg_rdata = mem_lo[m][7:0];
      if (reg_idx == idx8(MEM_BASE + MEM_STRIDE*m + 1))
        reg_rdata = {mem_w16[m], mem_zws[m], 2'b00, mem_lo[m][11:8]};
      if (reg_idx == idx8(MEM_BASE + MEM_STRIDE*m + 2)) reg_rdata = mem_hi[m][7:0];
      if (reg_idx == idx8(MEM_BASE + MEM_STRIDE*m + 3)) reg_rdata = {4'h0, mem_hi[m][11:8]};
    end
  end

  // R10: window state moves only on a write strobe
  a_r10_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable({io_lo, io_hi, io_en, mem_lo, mem_hi, mem_en, mem_w16, mem_zws}));
endmodule

// File: rtl/sock_win_cmp.sv
module sock_win_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         qual,
  output logic         hit
);
  assign hit = qual && (val >= lo) && (val <= hi);
endmodule

// File: rtl/sock_win_pick.sv
module sock_win_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [IW-1:0] sel
);
  always_comb begin
    sel = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (hits[i]) sel = IW'(i);
    end
  end
  assign any = |hits;
endmodule

// File: rtl/sock_win_dec.sv
module sock_win_dec
  import sock_win_pkg::*;
#(
  parameter int N_IO  = 2,
  parameter int N_MEM = 5,
  parameter int AW    = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_idx,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [23:0] bus_addr,
  input  logic        io_cyc,
  input  logic        mem_cyc,
  input  logic        card_wait_n,
  output logic        claim,
  output logic        io_hit,
  output logic        io_win,
  output logic        mem_hit,
  output logic [2:0]  mem_win,
  output logic        bus16,
  output logic        nows_n
);
  localparam int IO_IW  = (N_IO  > 1) ? $clog2(N_IO)  : 1;
  localparam int MEM_IW = (N_MEM > 1) ? $clog2(N_MEM) : 1;

  logic [N_IO-1:0][IO_AW-1:0]    io_lo, io_hi;
  logic [N_IO-1:0]               io_en, io_hits;
  logic [N_MEM-1:0][PAGE_W-1:0]  mem_lo, mem_hi;
  logic [N_MEM-1:0]              mem_en, mem_w16, mem_zws, mem_hits;
  logic [IO_IW-1:0]              io_sel;
  logic [MEM_IW-1:0]             mem_sel;
  logic [PAGE_W-1:0]             page;

  assign page = bus_addr[AW-1 -: PAGE_W];

  sock_win_regs #(.N_IO(N_IO), .N_MEM(N_MEM)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .io_lo(io_lo), .io_hi(io_hi), .io_en(io_en),
    .mem_lo(mem_lo), .mem_hi(mem_hi), .mem_en(mem_en),
    .mem_w16(mem_w16), .mem_zws(mem_zws)
  );

  for (genvar w = 0; w < N_IO; w++) begin : g_io
    sock_win_cmp #(.W(IO_AW)) cmp_i (
      .val(bus_addr[IO_AW-1:0]), .lo(io_lo[w]), .hi(io_hi[w]),
      .qual(io_cyc && io_en[w]), .hit(io_hits[w])
    );
  end

  for (genvar m = 0; m < N_MEM; m++) begin : g_mem
    sock_win_cmp #(.W(PAGE_W)) cmp_i (
      .val(page), .lo(mem_lo[m]), .hi(mem_hi[m]),
      .qual(mem_cyc && mem_en[m]), .hit(mem_hits[m])
    );
  end

  sock_win_pick #(.N(N_IO), .IW(IO_IW)) io_pick_i (
    .hits(io_hits), .any(io_hit), .sel(io_sel)
  );
  sock_win_pick #(.N(N_MEM), .IW(MEM_IW)) mem_pick_i (
    .hits(mem_hits), .any(mem_hit), .sel(mem_sel)
  );

  assign io_win  = io_sel[0];
  assign mem_win = 3'(mem_sel);
  assign claim   = io_hit || mem_hit;
  assign bus16   = mem_hit && mem_w16[mem_sel];
  assign nows_n  = !(mem_hit && mem_zws[mem_sel] && card_wait_n);

  logic [N_IO-1:0]  io_below;
  logic [N_MEM-1:0] mem_below;
  assign io_below  = (N_IO'(1)  << io_sel)  - N_IO'(1);
  assign mem_below = (N_MEM'(1) << mem_sel) - N_MEM'(1);

  a_r3_io_needs_io_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> io_cyc);
  a_r4_mem_needs_mem_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> mem_cyc);
  a_r5_io_win_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> io_en[io_sel]);
  a_r5_mem_win_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> mem_en[mem_sel]);
  a_r6_io_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> ((io_hits & io_below) == '0));
  a_r6_mem_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> ((mem_hits & mem_below) == '0));
  a_r7_width_on_mem_only: assert property (@(posedge clk) disable iff (!rst_n)
    bus16 |-> mem_hit);
  a_r8_wait_vetoes_nows: assert property (@(posedge clk) disable iff (!rst_n)
    !card_wait_n |-> nows_n);
endmodule

// File: tb/sock_win_dec_tb_top.sv
`timescale 1ns/1ps
module sock_win_dec_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_idx = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [23:0] bus_addr = 0;
  logic        io_cyc = 0, mem_cyc = 0, card_wait_n = 1;
  logic        claim, io_hit, io_win, mem_hit, bus16, nows_n;
  logic [2:0]  mem_win;
  int checks = 0, errors = 0;
  bit done = 0, run = 0;
  logic [7:0] mdl [0:255];

  always #2 clk = ~clk;

  sock_win_dec dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .io_cyc(io_cyc), .mem_cyc(mem_cyc), .card_wait_n(card_wait_n),
    .claim(claim), .io_hit(io_hit), .io_win(io_win), .mem_hit(mem_hit),
    .mem_win(mem_win), .bus16(bus16), .nows_n(nows_n)
  );

  function automatic logic [7:0] wmask(input int i);
    if (i == 6) return 8'hDF;
    if (i >= 8 && i < 16) return 8'hFF;
    if (i >= 16 && i < 56 && (i % 8) < 4) begin
      case (i % 8)
        1: return 8'hCF;
        3: return 8'h0F;
        default: return 8'hFF;
      endcase
    end
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < 256; i++) mdl[i] <= 8'h00;
    else if (reg_wr) mdl[reg_idx] <= reg_wdata & wmask(reg_idx);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, compared on every clock
  task automatic cmp_all();
    bit eio = 0, emem = 0;
    int eiow = 0, ememw = 0;
    for (int w = 0; w < 2; w++) begin
      int b = 8 + 4*w;
      int lo = {mdl[b+1], mdl[b]};
      int hi = {mdl[b+3], mdl[b+2]};
      int a = bus_addr[15:0];
      if (!eio && io_cyc && mdl[6][6+w] && lo <= a && a <= hi) begin eio = 1; eiow = w; end
    end
    for (int m = 0; m < 5; m++) begin
      int b = 16 + 8*m;
      int lo = {mdl[b+1][3:0], mdl[b]};
      int hi = {mdl[b+3][3:0], mdl[b+2]};
      int p = bus_addr[23:12];
      if (!emem && mem_cyc && mdl[6][m] && lo <= p && p <= hi) begin emem = 1; ememw = m; end
    end
    chk("R3 io_hit", io_hit, eio);
    if (eio) chk("R6 io_win", io_win, eiow);
    chk("R4 mem_hit", mem_hit, emem);
    if (emem) chk("R6 mem_win", mem_win, ememw);
    chk("R7 bus16", bus16, emem && mdl[16+8*ememw+1][7]);
    chk("R8 nows_n", nows_n, !(emem && mdl[16+8*ememw+1][6] && card_wait_n));
    chk("R9 claim", claim, eio || emem);
    chk("R2 rdata", reg_rdata, mdl[reg_idx]);
  endtask

  always @(negedge clk) if (rst_n && run) cmp_all();

  task automatic wreg(input int i, input int d);
    @(posedge clk); #1;
    reg_wr = 1; reg_idx = 8'(i); reg_wdata = 8'(d);
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic probe(input int a, input bit io, input bit mem);
    @(posedge clk); #1;
    bus_addr = 24'(a); io_cyc = io; mem_cyc = mem;
    @(negedge clk);
  endtask

  task automatic rd(input int i, input int exp, input string tag);
    @(posedge clk); #1; reg_idx = 8'(i);
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    run = 1;
    // R1 reset state
    rd(8'h08, 0, "R1 io start after reset");
    rd(8'h11, 0, "R1 mem attr after reset");
    rd(8'h06, 0, "R1 enables after reset");
    probe(24'h000000, 1, 1);
    chk("R1 no claim after reset", claim, 0);
    chk("R1 nows_n after reset", nows_n, 1);
    // I/O windows: 0300-031F and 0310-0400
    wreg(8'h08, 8'h00); wreg(8'h09, 8'h03); wreg(8'h0A, 8'h1F); wreg(8'h0B, 8'h03);
    wreg(8'h0C, 8'h10); wreg(8'h0D, 8'h03); wreg(8'h0E, 8'h00); wreg(8'h0F, 8'h04);
    probe(24'h000300, 1, 0);
    chk("R5 disabled io window", io_hit, 0);
    wreg(8'h06, 8'hC0);
    probe(24'h0002FF, 1, 0); chk("R3 below start", io_hit, 0);
    probe(24'h000300, 1, 0); chk("R3 start inclusive", io_hit, 1);
    probe(24'h00031F, 1, 0); chk("R6 io overlap lowest", io_win, 0);
    probe(24'h000320, 1, 0); chk("R3 second window", io_win, 1);
    probe(24'h000400, 1, 0); chk("R3 stop inclusive", io_hit, 1);
    probe(24'h000401, 1, 0); chk("R3 above stop", io_hit, 0);
    probe(24'hAB0300, 1, 0); chk("R3 upper bits ignored", io_hit, 1);
    probe(24'h000300, 0, 1); chk("R9 io ignores mem cycle", claim, 0);
    // memory windows
    wreg(8'h10, 8'hD0); wreg(8'h11, 8'hC0); wreg(8'h12, 8'hD1); wreg(8'h13, 8'h00);
    wreg(8'h18, 8'hD1); wreg(8'h19, 8'h00); wreg(8'h1A, 8'hEF); wreg(8'h1B, 8'h00);
    wreg(8'h30, 8'h00); wreg(8'h31, 8'h4F); wreg(8'h32, 8'hFF); wreg(8'h33, 8'h0F);
    wreg(8'h06, 8'hD3);
    probe(24'h0CFFFF, 0, 1); chk("R4 below page", mem_hit, 0);
    probe(24'h0D0000, 0, 1);
    chk("R4 first page", mem_win, 0);
    chk("R7 16-bit path", bus16, 1);
    chk("R8 zero wait", nows_n, 0);
    probe(24'h0D1FFF, 0, 1); chk("R6 mem overlap lowest", mem_win, 0);
    probe(24'h0D2000, 0, 1);
    chk("R4 window 1", mem_win, 1);
    chk("R7 8-bit path", bus16, 0);
    chk("R8 no request", nows_n, 1);
    probe(24'hF00000, 0, 1); chk("R4 window 4", mem_win, 4);
    chk("R8 window 4 zero wait", nows_n, 0);
    @(posedge clk); #1 card_wait_n = 0;
    @(negedge clk);
    chk("R8 wait vetoes", nows_n, 1);
    chk("R8 hit kept under wait", mem_hit, 1);
    @(posedge clk); #1 card_wait_n = 1;
    probe(24'h0D0300, 1, 1);
    chk("R9 both kinds claim", claim, 1);
    chk("R9 both kinds io", io_hit, 1);
    // R5 memory disable
    wreg(8'h06, 8'hD2);
    probe(24'h0D0000, 0, 1); chk("R5 disabled mem window", mem_hit, 0);
    probe(24'h0D1000, 0, 1); chk("R5 next window takes over", mem_win, 1);
    // R2 readback layout
    rd(8'h31, 8'h4F, "R2 attr readback");
    rd(8'h06, 8'hD2, "R2 enable readback");
    wreg(8'h33, 8'hFF); rd(8'h33, 8'h0F, "R2 stop high mask");
    wreg(8'h11, 8'hFF); rd(8'h11, 8'hCF, "R2 attr mask");
    wreg(8'h07, 8'h55); rd(8'h07, 8'h00, "R2 unmapped ignored");
    // R10 write and decode in one cycle
    probe(24'h000320, 1, 0);
    @(posedge clk); #1;
    reg_wr = 1; reg_idx = 8'h0A; reg_wdata = 8'h20;
    @(negedge clk);
    chk("R10 old bound before edge", io_win, 1);
    @(posedge clk); #1 reg_wr = 0;
    @(negedge clk);
    chk("R10 new bound after edge", io_win, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule